// File: doc/BRIEF.md
# Subroutine Return Stack Unit

This block keeps return addresses for a small 8-bit processor core. Call and interrupt entry push the address of the next instruction word, the current program counter plus two, onto a hardware stack. The same push can also copy the live working, status and bank-select registers into a set of shadow registers. A return-from-subroutine instruction word pops the newest address into the program counter. One bit of that word chooses whether the three core registers are also reloaded from their shadows in the same step.

A return takes two cycles. In the first cycle the block decodes the word and loads the popped address into the program counter. The second cycle is a flush slot, in which the block discards the prefetched instruction word. The core sees the flush on a dedicated output and must not issue any instruction word in that slot. The block counts stack occupancy with a 5-bit pointer. A pop on an empty stack sets an underflow flag that stays set until reset.

Top module: `return_stack_unit`

## Requirements
- R1: After a synchronous active-low reset, pc_o is 0, stk_ptr_o is 0, and flush_o, restore_o and stk_unf_o are 0.
- R2: A return is recognised only while instr_valid_i is 1 and instr_i is 16'h0012 or 16'h0013. Bits 15 to 1 must equal 15'h0009, and bit 0 is the restore flag. Any other word, or either return word with instr_valid_i at 0, starts no return and leaves pc_o unchanged.
- R3: An accepted return loads pc_o, at the next clock edge, with the most recently pushed entry that has not yet been popped, and stk_ptr_o falls by one. The order of returns is last-in, first-out.
- R4: When bit 0 of the return word is 1, restore_o is 1 in the cycle after acceptance, and w_o, status_o and bsr_o carry the shadow copies. When bit 0 is 0, restore_o stays 0.
- R5: While push_i is 1, the stack stores pc_o+2 and stk_ptr_o rises by one. While push_shadow_i is also 1, the shadows capture w_i, status_i and bsr_i in that cycle. A push without push_shadow_i leaves the shadows unchanged.
- R6: flush_o is 1 for exactly the one cycle after an accepted return. Any instruction word presented during that cycle is ignored.
- R7: A return accepted while stk_ptr_o is 0 loads pc_o with 0, keeps stk_ptr_o at 0 and sets stk_unf_o. stk_unf_o then stays 1 until reset.
- R8: The stack holds 31 entries. A push while stk_ptr_o is 31 is dropped, and the stored entries and the pointer are unchanged.
- R9: When push_i and a valid return word fall in the same cycle, the push is performed and the return is not accepted: flush_o stays 0 and pc_o is unchanged.
- R10: pc_load_i loads pc_o with pc_val_i at the next edge, unless a return is accepted in that cycle. The return takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_i | input | 16 | Instruction word under decode |
| instr_valid_i | input | 1 | instr_i is valid this cycle |
| push_i | input | 1 | Call or interrupt entry: push pc_o+2 |
| push_shadow_i | input | 1 | Capture core registers into shadows with the push |
| w_i | input | 8 | Live working register |
| status_i | input | 8 | Live status register |
| bsr_i | input | 8 | Live bank-select register |
| pc_load_i | input | 1 | Load program counter from pc_val_i |
| pc_val_i | input | 21 | Program counter load value |
| pc_o | output | 21 | Program counter |
| flush_o | output | 1 | Discard-prefetch slot of a return |
| restore_o | output | 1 | Core registers must be reloaded from w_o, status_o, bsr_o |
| w_o | output | 8 | Shadow working register value |
| status_o | output | 8 | Shadow status register value |
| bsr_o | output | 8 | Shadow bank-select register value |
| stk_ptr_o | output | 5 | Stack occupancy pointer |
| stk_unf_o | output | 1 | Sticky stack underflow flag |

## Verification
A stack push and a return decode can arrive in the same cycle, for example when an interrupt entry coincides with a return word. The bench provokes this by raising push_i while a valid return word is on instr_i. It judges the outcome at the ports: the pointer must rise and flush_o must stay low. A following return must then pop exactly the address that the push stored. The bench also presents a return word during the flush slot and checks that the program counter and the pointer are unaffected.

// File: rtl/rsu_pkg.sv
// Package: shared parameters and types for the return stack unit.
// Assumes: a 21-bit program counter and 8-bit core registers.
package rsu_pkg;
    localparam int unsigned PC_W    = 21;
    localparam int unsigned REG_W   = 8;
    localparam logic [14:0] RET_HI  = 15'h0009;  // instr[15:1] of a return word

    typedef enum logic {
        RS_IDLE  = 1'b0,
        RS_FLUSH = 1'b1
    } rs_state_t;

    typedef struct packed {
        logic [REG_W-1:0] w;
        logic [REG_W-1:0] status;
        logic [REG_W-1:0] bsr;
    } core_regs_t;
endpackage

// File: rtl/rsu_decode.sv
// Module: rsu_decode
// Recognises the return-from-subroutine word and extracts its restore flag.
// Assumes: instr_i is qualified by instr_valid_i; purely combinational.
module rsu_decode
    import rsu_pkg::*;
(
    input  logic        instr_valid_i,
    input  logic [15:0] instr_i,
    output logic        ret_hit_o,
    output logic        ret_restore_o
);
    // Match the fixed upper fifteen bits; bit 0 selects the shadow restore.
    always_comb begin
        ret_hit_o     = instr_valid_i && (instr_i[15:1] == RET_HI);
        ret_restore_o = instr_i[0];
    end
endmodule

// File: rtl/rsu_stack.sv
// Module: rsu_stack
// LIFO of return addresses with an occupancy pointer and a sticky underflow flag.
// Assumes: push and pop never arrive together (the caller gives push priority).
module rsu_stack #(
    parameter int unsigned DEPTH = 31,
    parameter int unsigned AW    = 21,
    localparam int unsigned PW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [AW-1:0] push_data_i,
    input  logic          pop_i,
    output logic [AW-1:0] top_o,
    output logic [PW-1:0] sp_o,
    output logic          unf_o
);
    localparam logic [PW-1:0] FULL_PTR = PW'(DEPTH);

    logic [AW-1:0] mem [DEPTH];
    logic [PW-1:0] sp_q;
    logic          unf_q;
    logic          empty, full;

    // Occupancy status derived from the pointer.
    always_comb begin
        empty = (sp_q == '0);
        full  = (sp_q == FULL_PTR);
        top_o = empty ? '0 : mem[sp_q - 1'b1];
    end

    // Entry storage: written at the pointer on a non-full push.
    always_ff @(posedge clk) begin
        if (push_i && !full)
            mem[sp_q] <= push_data_i;
    end

    // Pointer and underflow flag maintenance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q  <= '0;
            unf_q <= 1'b0;
        end else if (push_i) begin
            if (!full)
                sp_q <= sp_q + 1'b1;
        end else if (pop_i) begin
            if (empty)
                unf_q <= 1'b1;
            else
                sp_q <= sp_q - 1'b1;
        end
    end

    assign sp_o  = sp_q;
    assign unf_o = unf_q;

    AST_UNF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && empty) |=> (sp_q == '0 && unf_q)); // R7
    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        unf_q |=> unf_q); // R7
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full) |=> $stable(sp_q)); // R8
    AST_PUSH_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !full) |=> (sp_q == $past(sp_q) + 1'b1)); // R5
endmodule

// File: rtl/rsu_shadow.sv
// Module: rsu_shadow
// Holds shadow copies of the core registers and presents them on a restore.
// Assumes: capture and restore are never requested in the same cycle.
module rsu_shadow
    import rsu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_i,
    input  core_regs_t live_i,
    input  logic       restore_i,
    output logic       restore_o,
    output core_regs_t regs_o
);
    core_regs_t shd_q;

    // Capture the live core registers on a push that asks for it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shd_q <= '0;
        else if (cap_i)
            shd_q <= live_i;
    end

    // Present the shadows with a one-cycle restore strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            restore_o <= 1'b0;
            regs_o    <= '0;
        end else begin
            restore_o <= restore_i;
            if (restore_i)
                regs_o <= shd_q;
        end
    end

    AST_SHADOW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> $stable(shd_q)); // R5
    AST_NO_CAP_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_i && restore_i)); // R9
endmodule

// File: rtl/return_stack_unit.sv
// Module: return_stack_unit (top)
// Return-address stack with fast-context shadows and a two-cycle return.
// Assumes: the core stalls instruction issue while flush_o is high; a push
// takes priority over a return presented in the same cycle.
module return_stack_unit
    import rsu_pkg::*;
#(
    parameter int unsigned DEPTH = 31,
    localparam int unsigned PW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [15:0]      instr_i,
    input  logic             instr_valid_i,
    input  logic             push_i,
    input  logic             push_shadow_i,
    input  logic [REG_W-1:0] w_i,
    input  logic [REG_W-1:0] status_i,
    input  logic [REG_W-1:0] bsr_i,
    input  logic             pc_load_i,
    input  logic [PC_W-1:0]  pc_val_i,
    output logic [PC_W-1:0]  pc_o,
    output logic             flush_o,
    output logic             restore_o,
    output logic [REG_W-1:0] w_o,
    output logic [REG_W-1:0] status_o,
    output logic [REG_W-1:0] bsr_o,
    output logic [PW-1:0]    stk_ptr_o,
    output logic             stk_unf_o
);
    rs_state_t       state_q;
    logic            ret_hit, ret_s, ret_go;
    logic [PC_W-1:0] pc_q, top_addr;
    core_regs_t      live, shd_out;

    rsu_decode u_dec (
        .instr_valid_i (instr_valid_i),
        .instr_i       (instr_i),
        .ret_hit_o     (ret_hit),
        .ret_restore_o (ret_s)
    );

    // Accept a return only in the idle slot and when no push competes.
    always_comb begin
        ret_go      = ret_hit && (state_q == RS_IDLE) && !push_i;
        live.w      = w_i;
        live.status = status_i;
        live.bsr    = bsr_i;
    end

    rsu_stack #(.DEPTH(DEPTH), .AW(PC_W)) u_stk (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_i),
        .push_data_i (pc_q + PC_W'(2)),
        .pop_i       (ret_go),
        .top_o       (top_addr),
        .sp_o        (stk_ptr_o),
        .unf_o       (stk_unf_o)
    );

    rsu_shadow u_shd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_i     (push_i && push_shadow_i),
        .live_i    (live),
        .restore_i (ret_go && ret_s),
        .restore_o (restore_o),
        .regs_o    (shd_out)
    );

    // Two-slot sequencer: a return is followed by one flush slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= RS_IDLE;
        else if (state_q == RS_FLUSH)
            state_q <= RS_IDLE;
        else if (ret_go)
            state_q <= RS_FLUSH;
    end

    // Program counter: a popped address beats an external load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else if (ret_go)
            pc_q <= top_addr;
        else if (pc_load_i)
            pc_q <= pc_val_i;
    end

    assign pc_o     = pc_q;
    assign flush_o  = (state_q == RS_FLUSH);
    assign w_o      = shd_out.w;
    assign status_o = shd_out.status;
    assign bsr_o    = shd_out.bsr;

    AST_FLUSH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> !flush_o); // R6
    AST_RESTORE_IN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        restore_o |-> flush_o); // R4
    AST_PUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && ret_hit && !flush_o) |=> !flush_o); // R9
    AST_FLUSH_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_o && !pc_load_i) |=> $stable(pc_o)); // R6
    AST_HIT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ret_hit |-> instr_valid_i); // R2
endmodule

// File: tb/sim_return_stack_unit.sv
module sim_return_stack_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] instr_i;
    logic        instr_valid_i, push_i, push_shadow_i, pc_load_i;
    logic [7:0]  w_i, status_i, bsr_i;
    logic [20:0] pc_val_i;
    logic [20:0] pc_o;
    logic        flush_o, restore_o, stk_unf_o;
    logic [7:0]  w_o, status_o, bsr_o;
    logic [4:0]  stk_ptr_o;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;  // 50 MHz

    return_stack_unit u0 (.*);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        instr_i = 16'h0000; instr_valid_i = 0; push_i = 0; push_shadow_i = 0;
        pc_load_i = 0; pc_val_i = '0; w_i = 0; status_i = 0; bsr_i = 0;
    endtask

    task automatic load_pc(input logic [20:0] v);
        pc_load_i = 1; pc_val_i = v; step(); pc_load_i = 0;
    endtask

    task automatic do_push(input bit shd, input logic [7:0] w, input logic [7:0] st, input logic [7:0] b);
        push_i = 1; push_shadow_i = shd; w_i = w; status_i = st; bsr_i = b;
        step();
        push_i = 0; push_shadow_i = 0;
    endtask

    task automatic t_reset();
        chk(pc_o == 0, "R1 pc", pc_o, 0);
        chk(stk_ptr_o == 0, "R1 ptr", stk_ptr_o, 0);
        chk(!flush_o && !restore_o && !stk_unf_o, "R1 flags", {flush_o, restore_o, stk_unf_o}, 0);
    endtask

    task automatic t_load_and_push();
        load_pc(21'h000100);
        chk(pc_o == 21'h100, "R10 pc load", pc_o, 21'h100);
        do_push(1, 8'hAA, 8'h1F, 8'h03);
        chk(stk_ptr_o == 1, "R5 ptr after push", stk_ptr_o, 1);
        chk(pc_o == 21'h100, "R5 pc unchanged by push", pc_o, 21'h100);
        load_pc(21'h002000);
        do_push(0, 8'h11, 8'h22, 8'h33);
        chk(stk_ptr_o == 2, "R5 ptr second push", stk_ptr_o, 2);
        load_pc(21'h000005);
    endtask

    task automatic t_ret_plain();
        instr_i = 16'h0012; instr_valid_i = 1; pc_load_i = 1; pc_val_i = 21'h1ABCD;
        step();
        pc_load_i = 0;
        chk(pc_o == 21'h2002, "R3 R10 pop beats load", pc_o, 21'h2002);
        chk(flush_o == 1, "R6 flush slot", flush_o, 1);
        chk(restore_o == 0, "R4 no restore s=0", restore_o, 0);
        chk(stk_ptr_o == 1, "R3 ptr dec", stk_ptr_o, 1);
        instr_i = 16'h0013;  // presented during flush: must be ignored
        step();
        instr_valid_i = 0;
        chk(flush_o == 0, "R6 flush one cycle", flush_o, 0);
        chk(pc_o == 21'h2002 && stk_ptr_o == 1, "R6 word in flush ignored", {pc_o, stk_ptr_o}, {21'h2002, 5'd1});
    endtask

    task automatic t_ret_restore();
        instr_i = 16'h0013; instr_valid_i = 1;
        step();
        instr_valid_i = 0;
        chk(pc_o == 21'h102, "R3 LIFO second pop", pc_o, 21'h102);
        chk(restore_o == 1, "R4 restore strobe", restore_o, 1);
        chk({w_o, status_o, bsr_o} == 24'hAA1F03, "R4 R5 shadow values", {w_o, status_o, bsr_o}, 24'hAA1F03);
        step();
        chk(restore_o == 0, "R4 strobe single", restore_o, 0);
    endtask

    task automatic t_nonret();
        logic [15:0] words [3] = '{16'h0014, 16'h0010, 16'h8012};
        load_pc(21'h000444);
        do_push(0, 0, 0, 0);
        for (int i = 0; i < 3; i++) begin
            instr_i = words[i]; instr_valid_i = 1;
            step();
            instr_valid_i = 0;
            chk(!flush_o && pc_o == 21'h444, "R2 non-return word", {flush_o, pc_o}, {1'b0, 21'h444});
        end
        instr_i = 16'h0012; instr_valid_i = 0;
        step();
        chk(!flush_o && stk_ptr_o == 1, "R2 invalid return word", {flush_o, stk_ptr_o}, {1'b0, 5'd1});
    endtask

    task automatic t_same_cycle();
        instr_i = 16'h0012; instr_valid_i = 1; push_i = 1;
        step();
        instr_valid_i = 0; push_i = 0;
        chk(stk_ptr_o == 2, "R9 push performed", stk_ptr_o, 2);
        chk(!flush_o && pc_o == 21'h444, "R9 return dropped", {flush_o, pc_o}, {1'b0, 21'h444});
        instr_valid_i = 1;
        step(); instr_valid_i = 0;
        chk(pc_o == 21'h446, "R9 pushed entry popped", pc_o, 21'h446);
        step();
        instr_valid_i = 1;
        step(); instr_valid_i = 0;
        chk(stk_ptr_o == 0, "R3 drained", stk_ptr_o, 0);
        step();
    endtask

    task automatic t_underflow();
        load_pc(21'h000777);
        instr_i = 16'h0012; instr_valid_i = 1;
        step(); instr_valid_i = 0;
        chk(pc_o == 0 && stk_ptr_o == 0, "R7 underflow pc/ptr", {pc_o, stk_ptr_o}, 0);
        chk(stk_unf_o == 1, "R7 flag set", stk_unf_o, 1);
        step(); step();
        chk(stk_unf_o == 1, "R7 flag sticky", stk_unf_o, 1);
    endtask

    task automatic t_full();
        for (int i = 0; i < 31; i++) begin
            load_pc(21'(i * 4));
            do_push(0, 0, 0, 0);
        end
        chk(stk_ptr_o == 31, "R8 full", stk_ptr_o, 31);
        load_pc(21'h0FFFF0);
        do_push(0, 0, 0, 0);
        chk(stk_ptr_o == 31, "R8 push dropped", stk_ptr_o, 31);
        instr_i = 16'h0012; instr_valid_i = 1;
        step(); instr_valid_i = 0;
        chk(pc_o == 21'd122, "R8 top intact", pc_o, 122);
        chk(stk_ptr_o == 30, "R8 ptr after pop", stk_ptr_o, 30);
        step();
    endtask

    initial begin
        idle_inputs();
        rst_n = 0;
        step(); step();
        rst_n = 1;
        t_reset();
        t_load_and_push();
        t_ret_plain();
        t_ret_restore();
        t_nonret();
        t_same_cycle();
        t_underflow();
        t_full();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule